// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Sequencer

This block is the digital control core of an 8-bit serial converter built on successive approximation. A host selects the block with an active-low select, toggles a serial clock and sends a data-in stream. The block skips any number of leading zeros and treats the first 1 as the start bit. It then captures a short channel-select word, allows one serial clock for the input multiplexer to settle, and then runs one successive-approximation step on each falling serial-clock edge.

The analog side is reduced to two signals. The block drives an 8-bit trial code to an external ladder and reads back one comparator bit. Each decision appears on the serial data-out line as soon as it resolves, most significant bit first. The captured result is then played back least significant bit first. A hold input can pause this playback, or the playback can run freely in a build option that has no hold control. Data-out has a separate output enable, so a pad outside the block can tri-state it.

All inputs are sampled on one fast system clock. The serial clock is treated as a data signal, and its edges are detected inside the block.

Top module: `sar_serial_ctl`

## Requirements
- R1: While select is low and no start bit has arrived, a 0 sampled on a rising serial-clock edge leaves the block idle, with `dout_oe`=0 and `busy`=0. The start-bit edge itself does not enable data-out.
- R2: The ADDR_W data-in bits sampled on the rising edges after the start bit form `mux_addr`, first bit received in the most significant position. The value holds until select rises.
- R3: On the rising edge that takes the last address bit, `busy` and `dout_oe` go to 1 and `dout` is driven to 0 for the settling period. After that point, data-in has no effect on `mux_addr` or on the result.
- R4: At settle, `trial_code` is 0x80. On each decision the current trial bit is kept when `comp`=1 (input at or above the trial level) and cleared when `comp`=0, and the next lower bit is set. After 8 decisions `trial_code` holds the result.
- R5: On the first falling serial-clock edge after the settling clock, and on each following one, `dout` takes the new decision, bit 7 first and bit 0 last.
- R6: `busy` stays 1 through the conversion and drops on the falling edge that produces bit 0.
- R7: With USE_SE=1 and `lsb_hold`=0, each later falling edge places result bits 1 through 7 on `dout` in turn. Bit 0 is already shown.
- R8: With USE_SE=1 and `lsb_hold`=1, falling edges during playback leave `dout` unchanged, so it keeps showing the bit it holds.
- R9: With USE_SE=0, playback of bits 1 to 7 runs on the falling edges after the conversion whatever the value of `lsb_hold`.
- R10: After bit 7 has been played back, the next falling edge drives `dout` to 0 with `dout_oe`=1. Both stay that way until select rises.
- R11: Within one system clock of select being high, `dout_oe`, `busy`, `trial_code` and `mux_addr` are cleared, and serial activity has no effect. After select falls again, a new start bit is needed.
- R12: Synchronous active-high `rst` clears the block the same way as R11, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select; high clears the block |
| sclk | input | 1 | Serial clock, edge-detected internally |
| din | input | 1 | Serial data in: start bit and channel word |
| comp | input | 1 | Comparator decision for the current trial code |
| lsb_hold | input | 1 | 1 pauses LSB-first playback (USE_SE=1 only) |
| trial_code | output | RES_W | Code driven to the external ladder |
| mux_addr | output | ADDR_W | Captured channel-select word |
| busy | output | 1 | Conversion in progress |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output enable for the data-out pad |

## Verification
The assertions assume that `sclk`, `din`, `cs_n` and `lsb_hold` change synchronously to `clk`. They also assume that every serial-clock level lasts at least one system clock, so each serial edge is seen exactly once. The bench drives all of these inputs on the falling system-clock edge and holds each serial-clock phase for four system clocks. The assertions also assume that `comp` is settled when a falling serial-clock edge is detected. The bench meets this by deriving `comp` combinationally from the present `trial_code` and a fixed input value, which never changes during a conversion.

// File: rtl/sar_ser_pkg.sv
package sar_ser_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SETTLE,
        ST_CONV,
        ST_REPLAY,
        ST_TAIL
    } seq_st_t;

    typedef enum logic [1:0] {
        DO_KEEP,
        DO_ZERO,
        DO_BIT,
        DO_SHIFT
    } dout_cmd_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } sclk_ev_t;

    function automatic logic [31:0] top_bit_mask(input int width);
        return 32'd1 << (width - 1);
    endfunction

endpackage

// File: rtl/sar_sclk_edge.sv
module sar_sclk_edge
    import sar_ser_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk,
    output sclk_ev_t ev
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk;
    end

    assign ev.rise = sclk & ~sclk_q;
    assign ev.fall = ~sclk & sclk_q;
endmodule

// File: rtl/sar_approx.sv
module sar_approx
    import sar_ser_pkg::*;
#(
    parameter int RES_W = 8,
    localparam int IDX_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic             step,
    input  logic             comp,
    input  logic [IDX_W-1:0] idx,
    output logic [RES_W-1:0] trial
);
    localparam logic [RES_W-1:0] FIRST_TRIAL = RES_W'(top_bit_mask(RES_W));

    logic [RES_W-1:0] trial_nxt;

    always_comb begin
        trial_nxt = trial;
        for (int i = 0; i < RES_W; i++) begin
            if (i == int'(idx))
                trial_nxt[i] = comp;
            else if (idx != '0 && i == int'(idx) - 1)
                trial_nxt[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (clr)       trial <= '0;
        else if (load) trial <= FIRST_TRIAL;
        else if (step) trial <= trial_nxt;
    end

    // R4: a rejected trial bit never survives the step that decides it
    p_reject_clears_r4: assert property (@(posedge clk) disable iff (clr)
        (step && !comp && idx == IDX_W'(RES_W-1)) |=> !trial[RES_W-1]);
endmodule

// File: rtl/sar_dout_shift.sv
module sar_dout_shift
    import sar_ser_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic      clk,
    input  logic      clr,
    input  dout_cmd_t cmd,
    input  logic      bit_in,
    output logic      dout,
    output logic      dout_oe
);
    logic [RES_W-1:0] rep;

    always_ff @(posedge clk) begin
        if (clr) begin
            rep     <= '0;
            dout    <= 1'b0;
            dout_oe <= 1'b0;
        end else begin
            unique case (cmd)
                DO_ZERO: begin
                    dout    <= 1'b0;
                    dout_oe <= 1'b1;
                end
                DO_BIT: begin
                    dout    <= bit_in;
                    dout_oe <= 1'b1;
                    rep     <= {rep[RES_W-2:0], bit_in};
                end
                DO_SHIFT: begin
                    dout <= rep[1];
                    rep  <= rep >> 1;
                end
                default: ;
            endcase
        end
    end

    // R7: playback only happens on a line that is already driven
    p_shift_driven_r7: assert property (@(posedge clk) disable iff (clr)
        (cmd == DO_SHIFT) |-> dout_oe);
endmodule

// File: rtl/sar_serial_ctl.sv
module sar_serial_ctl
    import sar_ser_pkg::*;
#(
    parameter int RES_W  = 8,
    parameter int ADDR_W = 4,
    parameter bit USE_SE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              comp,
    input  logic              lsb_hold,
    output logic [RES_W-1:0]  trial_code,
    output logic [ADDR_W-1:0] mux_addr,
    output logic              busy,
    output logic              dout,
    output logic              dout_oe
);
    localparam int IDX_W = $clog2(RES_W);
    localparam int CNT_W = $clog2(ADDR_W);
    localparam logic [CNT_W-1:0] ACNT_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [IDX_W-1:0] IDX_TOP   = IDX_W'(RES_W - 1);

    seq_st_t          st;
    sclk_ev_t         ev;
    dout_cmd_t        cmd;
    logic [CNT_W-1:0] acnt;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] rcnt;
    logic             clr, addr_done, step, adv, rep_ev;

    assign clr       = rst | cs_n;
    assign addr_done = (st == ST_ADDR) && ev.rise && (acnt == ACNT_LAST);
    assign step      = (st == ST_CONV) && ev.fall;
    assign adv       = !lsb_hold || !USE_SE;
    assign rep_ev    = (st == ST_REPLAY) && ev.fall && adv;

    always_comb begin
        cmd = DO_KEEP;
        if (addr_done)   cmd = DO_ZERO;
        else if (step)   cmd = DO_BIT;
        else if (rep_ev) cmd = (rcnt == '0) ? DO_ZERO : DO_SHIFT;
    end

    sar_sclk_edge u_edge (
        .clk  (clk),
        .rst  (clr),
        .sclk (sclk),
        .ev   (ev)
    );

    sar_approx #(.RES_W(RES_W)) u_approx (
        .clk   (clk),
        .clr   (clr),
        .load  (addr_done),
        .step  (step),
        .comp  (comp),
        .idx   (idx),
        .trial (trial_code)
    );

    sar_dout_shift #(.RES_W(RES_W)) u_dout (
        .clk     (clk),
        .clr     (clr),
        .cmd     (cmd),
        .bit_in  (comp),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    always_ff @(posedge clk) begin
        if (clr) begin
            st       <= ST_IDLE;
            acnt     <= '0;
            idx      <= '0;
            rcnt     <= '0;
            mux_addr <= '0;
            busy     <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (ev.rise && din) begin
                    st   <= ST_ADDR;
                    acnt <= '0;
                end
                ST_ADDR: if (ev.rise) begin
                    mux_addr <= {mux_addr[ADDR_W-2:0], din};
                    if (acnt == ACNT_LAST) begin
                        st   <= ST_SETTLE;
                        busy <= 1'b1;
                    end else begin
                        acnt <= acnt + 1'b1;
                    end
                end
                ST_SETTLE: if (ev.rise) begin
                    st  <= ST_CONV;
                    idx <= IDX_TOP;
                end
                ST_CONV: if (ev.fall) begin
                    if (idx == '0) begin
                        st   <= ST_REPLAY;
                        busy <= 1'b0;
                        rcnt <= IDX_TOP;
                    end else begin
                        idx <= idx - 1'b1;
                    end
                end
                ST_REPLAY: if (rep_ev) begin
                    if (rcnt == '0) st <= ST_TAIL;
                    else            rcnt <= rcnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R11: select high clears every visible output by the next clock
    p_cs_clears_r11: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!dout_oe && !busy && trial_code == '0 && mux_addr == '0));

    // R3: a running conversion always drives data-out
    p_busy_drives_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> dout_oe);

    // R4: the search starts from the mid-scale code
    p_first_trial_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> trial_code == RES_W'(top_bit_mask(RES_W)));

    // R2: the channel word is frozen for the whole conversion
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst || cs_n)
        (busy && $past(busy)) |-> $stable(mux_addr));

    // R1: no drive on data-out before a start bit
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> (!dout_oe && !busy));
endmodule

// File: tb/sar_serial_ctl_tb.sv
module sar_serial_ctl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, cs2_n = 1'b1;
    logic sclk = 1'b0, din = 1'b0, lsb_hold = 1'b0;
    logic [7:0] vin = 8'h00;

    logic [7:0] trial1, trial2;
    logic [3:0] addr1;
    logic [2:0] addr2;
    logic busy1, dout1, oe1, busy2, dout2, oe2;
    logic comp1, comp2;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    assign comp1 = (vin >= trial1);
    assign comp2 = (vin >= trial2);

    sar_serial_ctl #(.RES_W(8), .ADDR_W(4), .USE_SE(1'b1)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .comp(comp1), .lsb_hold(lsb_hold), .trial_code(trial1),
        .mux_addr(addr1), .busy(busy1), .dout(dout1), .dout_oe(oe1));

    sar_serial_ctl #(.RES_W(8), .ADDR_W(3), .USE_SE(1'b0)) dut_auto_i (
        .clk(clk), .rst(rst), .cs_n(cs2_n), .sclk(sclk), .din(din),
        .comp(comp2), .lsb_hold(lsb_hold), .trial_code(trial2),
        .mux_addr(addr2), .busy(busy2), .dout(dout2), .dout_oe(oe2));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic v);
        din = v;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic release_cs();
        cs_n  = 1'b1;
        cs2_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        cs_n = 1'b0;
        for (int i = 0; i < 3; i++) tick(1'b1);
        chk("R12 oe in reset", oe1, 0);
        chk("R12 busy in reset", busy1, 0);
        chk("R12 trial in reset", trial1, 0);
        chk("R12 addr in reset", addr1, 0);
        rst = 1'b0;
        release_cs();
    endtask

    task automatic t_conv(input logic [3:0] a, input logic [7:0] v, input int nz);
        vin  = v;
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nz; i++) begin
            tick(1'b0);
            chk("R1 oe on leading zero", oe1, 0);
            chk("R1 busy on leading zero", busy1, 0);
        end
        tick(1'b1);
        chk("R1 oe after start bit", oe1, 0);
        for (int i = 3; i >= 0; i--) tick(a[i]);
        chk("R2 channel word", addr1, a);
        chk("R3 busy at settle", busy1, 1);
        chk("R3 oe at settle", oe1, 1);
        chk("R3 leading zero", dout1, 0);
        chk("R4 first trial", trial1, 8'h80);
        for (int k = 0; k < 8; k++) begin
            tick(k[0]);
            chk("R5 msb-first bit", dout1, v[7-k]);
            chk("R6 busy during conversion", busy1, (k < 7) ? 1 : 0);
        end
        chk("R4 final code", trial1, v);
        chk("R3 din ignored for channel", addr1, a);
    endtask

    task automatic t_replay_free(input logic [7:0] v);
        lsb_hold = 1'b0;
        for (int k = 1; k < 8; k++) begin
            tick(1'b1);
            chk("R7 lsb-first bit", dout1, v[k]);
        end
        tick(1'b0);
        chk("R10 low after playback", dout1, 0);
        chk("R10 still driven", oe1, 1);
        tick(1'b1);
        tick(1'b1);
        chk("R10 stays low", dout1, 0);
        chk("R10 stays driven", oe1, 1);
        release_cs();
    endtask

    task automatic t_replay_hold(input logic [7:0] v);
        lsb_hold = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick(1'b0);
            chk("R8 held lsb", dout1, v[0]);
        end
        lsb_hold = 1'b0;
        for (int k = 1; k < 8; k++) begin
            tick(1'b0);
            chk("R7 lsb-first after hold", dout1, v[k]);
        end
        tick(1'b0);
        chk("R10 low after held playback", dout1, 0);
        release_cs();
    endtask

    task automatic t_abort();
        vin  = 8'h5c;
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        tick(1'b1);
        for (int i = 0; i < 4; i++) tick(1'b1);
        for (int i = 0; i < 3; i++) tick(1'b0);
        chk("R6 busy mid conversion", busy1, 1);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 oe cleared", oe1, 0);
        chk("R11 busy cleared", busy1, 0);
        chk("R11 trial cleared", trial1, 0);
        chk("R11 addr cleared", addr1, 0);
        for (int i = 0; i < 3; i++) tick(1'b1);
        chk("R11 sclk ignored while deselected", oe1, 0);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 6; i++) tick(1'b0);
        chk("R11 needs new start bit oe", oe1, 0);
        chk("R11 needs new start bit busy", busy1, 0);
        release_cs();
    endtask

    task automatic t_auto(input logic [2:0] a, input logic [7:0] v);
        vin      = v;
        lsb_hold = 1'b1;
        cs2_n    = 1'b0;
        repeat (2) @(negedge clk);
        tick(1'b0);
        tick(1'b1);
        for (int i = 2; i >= 0; i--) tick(a[i]);
        chk("R2 three-bit channel word", addr2, a);
        chk("R3 busy at settle (auto)", busy2, 1);
        for (int k = 0; k < 8; k++) begin
            tick(1'b1);
            chk("R5 msb-first bit (auto)", dout2, v[7-k]);
        end
        for (int k = 1; k < 8; k++) begin
            tick(1'b0);
            chk("R9 automatic lsb-first bit", dout2, v[k]);
        end
        tick(1'b0);
        chk("R10 low after auto playback", dout2, 0);
        lsb_hold = 1'b0;
        release_cs();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_conv(4'hb, 8'ha5, 3);
        t_replay_free(8'ha5);
        t_conv(4'h3, 8'hff, 0);
        t_replay_hold(8'hff);
        t_conv(4'h8, 8'h00, 1);
        t_replay_free(8'h00);
        t_abort();
        t_conv(4'h6, 8'h36, 2);
        t_replay_hold(8'h36);
        t_auto(3'b101, 8'h9e);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule